// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block is the device-side logic of a small flash memory that reports progress while an internal program or erase operation runs. A host writes commands through a write strobe carrying an already decoded command code, an address and a data word. The block runs a timed operation engine. Each read strobe returns either the addressed array word, when the device is idle, or a status word, when an operation is active, locked up or failed. The status word holds a toggle bit that inverts on every status read, a time-limit flag, a flag naming the phase that overran, and a flag that shows whether the sector-erase acceptance window has closed.

The array is a small register memory. It is split into equal sectors, and a word's sector is the top SB bits of its address. A program operation can only clear bits. Asking for a bit to go from 0 to 1 locks the engine up until the time limit expires. An erase operation sets every word of the selected sectors to all ones. When the scaled variant is chosen, erase time grows with the number of selected sectors, so a large erase can overrun the limit.

Top module: `flash_status_gen`

## Requirements
- R1: After reset every array word is all ones and rd_data is 0. While idle, a read strobe puts the word at rd_addr on rd_data one cycle later. rd_data holds its value in cycles without a read strobe.
- R2: While an operation is active, locked or failed, a read strobe returns a status word instead of array data. Bit 6 is the inverse of the bit 6 returned by the previous status read, and the first status read after reset gives 1. Bits 7, 2, 1 and 0 are 0. The toggling continues during the sector-erase window and in the failed state.
- R3: Write command code 1 (program) while idle to start a program operation that lasts PROG_CYC cycles. At the end, the word becomes its old value ANDed with the write data. A read in the same cycle as the accepting write still sees the idle view.
- R4: Write command code 2 (sector erase) while idle to open a window of WIN_CYC cycles, during which status bit 3 reads 0. Further code-2 writes inside the window add their sectors to the erase set. When the window closes, bit 3 reads 1.
- R5: Command code 3 (chip erase) selects every sector and starts the erase at once, with bit 3 at 1. An erase lasts ERASE_CYC cycles per selected sector, and on completion every word of the selected sectors is all ones.
- R6: While an operation is active, every write is ignored, except code-2 writes inside the window and the reset command (code 0) in the failed state.
- R7: A program that would set a 0 bit to 1 never completes: status toggling continues, and after LIMIT_CYC cycles the block fails with bit 5 = 1 and bit 4 = 0. An erase longer than LIMIT_CYC fails at LIMIT_CYC with bit 5 = 1, bit 4 = 1 and bit 3 = 1. A failed operation leaves the array unchanged.
- R8: Command code 0 (reset) in the failed state returns the block to idle reads with bit 5 cleared. In the idle state it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, one cycle per command |
| wr_cmd | input | 2 | Decoded command: 0 reset, 1 program, 2 sector erase, 3 chip erase |
| wr_addr | input | AW | Word address for program, or any address inside the sector to erase |
| wr_data | input | DW | Program data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | AW | Word address for array reads |
| rd_data | output | DW | Array word or status word, registered |

## Verification
A read strobe and a state change of the engine can fall in the same cycle. Examples are a read issued together with the accepting command write, a read on the edge where the program result is committed to the array, and a read on the edge where the window closes or the limit expires. The bench provokes these with directed steps that read the addressed word in the same cycle as the command. It then adds a long stretch of mixed stimulus with a read almost every cycle and commands arriving at arbitrary engine phases. Each result is judged against a behavioural reference model that applies every edge in a fixed order: the read sees the state before the edge, and only then does the engine move on.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

   typedef enum logic [1:0] {
      CMD_RESET = 2'd0,
      CMD_PROG  = 2'd1,
      CMD_SECT  = 2'd2,
      CMD_CHIP  = 2'd3
   } fsg_cmd_e;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_WIN   = 3'd1,
      ST_PROG  = 3'd2,
      ST_ERASE = 3'd3,
      ST_FAIL  = 3'd4
   } fsg_state_e;

   localparam int STAT_TOGGLE_BIT = 6;
   localparam int STAT_LIMIT_BIT  = 5;
   localparam int STAT_PHASE_BIT  = 4;
   localparam int STAT_WINDOW_BIT = 3;

endpackage

// File: rtl/fsg_array.sv
module fsg_array #(
   parameter int DW = 8,
   parameter int AW = 4,
   parameter int SB = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [AW-1:0]        rd_addr,
   output logic [DW-1:0]        rd_word,
   input  logic [AW-1:0]        chk_addr,
   output logic [DW-1:0]        chk_word,
   input  logic                 prog_commit,
   input  logic [AW-1:0]        prog_addr,
   input  logic [DW-1:0]        prog_data,
   input  logic                 erase_commit,
   input  logic [(1<<SB)-1:0]   erase_sel
);
   localparam int DEPTH = 1 << AW;
   localparam int SH    = AW - SB;

   logic [DW-1:0] words [DEPTH];

   for (genvar w = 0; w < DEPTH; w++) begin : g_word
      localparam int SECT = w >> SH;
      logic [DW-1:0] word_q;
      logic          hit_erase;
      logic          hit_prog;

      assign hit_erase = erase_commit && erase_sel[SECT];
      assign hit_prog  = prog_commit && (prog_addr == AW'(w));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         word_q <= '1;
         else if (hit_erase) word_q <= '1;
         else if (hit_prog)  word_q <= word_q & prog_data;
      end

      assign words[w] = word_q;
   end

   assign rd_word  = words[rd_addr];
   assign chk_word = words[chk_addr];

endmodule

// File: rtl/fsg_engine.sv
module fsg_engine
   import fsg_pkg::*;
#(
   parameter int DW          = 8,
   parameter int AW          = 4,
   parameter int SB          = 2,
   parameter int PROG_CYC    = 6,
   parameter int ERASE_CYC   = 10,
   parameter int WIN_CYC     = 8,
   parameter int LIMIT_CYC   = 32,
   parameter int ERASE_SCALE = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [1:0]           wr_cmd,
   input  logic [AW-1:0]        wr_addr,
   input  logic [DW-1:0]        wr_data,
   input  logic [DW-1:0]        chk_word,
   output fsg_state_e           state,
   output logic                 fail_erase,
   output logic                 prog_commit,
   output logic [AW-1:0]        prog_addr,
   output logic [DW-1:0]        prog_data,
   output logic                 erase_commit,
   output logic [(1<<SB)-1:0]   erase_sel
);
   localparam int NSECT = 1 << SB;
   localparam int CMAX  = (LIMIT_CYC > WIN_CYC) ? LIMIT_CYC : WIN_CYC;
   localparam int CW    = $clog2(CMAX + 1);

   fsg_state_e       state_q;
   logic [CW-1:0]    cnt_q;
   logic             bad_q;
   logic             fph_q;
   logic [AW-1:0]    pa_q;
   logic [DW-1:0]    pd_q;
   logic [NSECT-1:0] sel_q;

   logic [NSECT-1:0] wr_onehot;
   logic [31:0]      dur;
   logic             dur_ok, end_hit, lim_hit, prog_done, win_done;

   assign wr_onehot = NSECT'(1) << wr_addr[AW-1 -: SB];

   if (ERASE_SCALE != 0) begin : g_scaled
      assign dur = 32'(ERASE_CYC) * 32'($countones(sel_q));
   end else begin : g_fixed
      assign dur = 32'(ERASE_CYC);
   end

   assign dur_ok    = (dur != 32'd0) && (dur <= 32'(LIMIT_CYC));
   assign end_hit   = (32'(cnt_q) + 32'd1) == dur;
   assign lim_hit   = cnt_q == CW'(LIMIT_CYC - 1);
   assign prog_done = !bad_q && (cnt_q == CW'(PROG_CYC - 1));
   assign win_done  = cnt_q == CW'(WIN_CYC - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         bad_q   <= 1'b0;
         fph_q   <= 1'b0;
         pa_q    <= '0;
         pd_q    <= '0;
         sel_q   <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (wr_en) begin
                  case (fsg_cmd_e'(wr_cmd))
                     CMD_PROG: begin
                        state_q <= ST_PROG;
                        cnt_q   <= '0;
                        pa_q    <= wr_addr;
                        pd_q    <= wr_data;
                        bad_q   <= (chk_word & wr_data) != wr_data;
                     end
                     CMD_SECT: begin
                        state_q <= ST_WIN;
                        cnt_q   <= '0;
                        sel_q   <= wr_onehot;
                     end
                     CMD_CHIP: begin
                        state_q <= ST_ERASE;
                        cnt_q   <= '0;
                        sel_q   <= '1;
                     end
                     default: ;
                  endcase
               end
            end
            ST_WIN: begin
               if (wr_en && (fsg_cmd_e'(wr_cmd) == CMD_SECT))
                  sel_q <= sel_q | wr_onehot;
               if (win_done) begin
                  state_q <= ST_ERASE;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_PROG: begin
               if (prog_done) begin
                  state_q <= ST_IDLE;
               end else if (lim_hit) begin
                  state_q <= ST_FAIL;
                  fph_q   <= 1'b0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_ERASE: begin
               if (dur_ok && end_hit) begin
                  state_q <= ST_IDLE;
               end else if (lim_hit) begin
                  state_q <= ST_FAIL;
                  fph_q   <= 1'b1;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_FAIL: begin
               if (wr_en && (fsg_cmd_e'(wr_cmd) == CMD_RESET))
                  state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign state        = state_q;
   assign fail_erase   = fph_q;
   assign prog_commit  = (state_q == ST_PROG) && prog_done;
   assign prog_addr    = pa_q;
   assign prog_data    = pd_q;
   assign erase_commit = (state_q == ST_ERASE) && dur_ok && end_hit;
   assign erase_sel    = sel_q;

endmodule

// File: rtl/fsg_status.sv
module fsg_status
   import fsg_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_en,
   input  fsg_state_e    state,
   input  logic          fail_erase,
   input  logic [DW-1:0] rd_word,
   output logic [DW-1:0] rd_data
);
   logic          tog_q;
   logic [DW-1:0] stat_w;
   logic          failed;

   assign failed = state == ST_FAIL;

   always_comb begin
      stat_w                  = '0;
      stat_w[STAT_TOGGLE_BIT] = ~tog_q;
      stat_w[STAT_LIMIT_BIT]  = failed;
      stat_w[STAT_PHASE_BIT]  = failed && fail_erase;
      stat_w[STAT_WINDOW_BIT] = (state == ST_ERASE) || (failed && fail_erase);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data <= '0;
         tog_q   <= 1'b0;
      end else if (rd_en) begin
         if (state == ST_IDLE) begin
            rd_data <= rd_word;
         end else begin
            rd_data <= stat_w;
            tog_q   <= ~tog_q;
         end
      end
   end

endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
   import fsg_pkg::*;
#(
   parameter int DW          = 8,
   parameter int AW          = 4,
   parameter int SB          = 2,
   parameter int PROG_CYC    = 6,
   parameter int ERASE_CYC   = 10,
   parameter int WIN_CYC     = 8,
   parameter int LIMIT_CYC   = 32,
   parameter int ERASE_SCALE = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [1:0]    wr_cmd,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic          rd_en,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data
);
   localparam int NSECT = 1 << SB;

   if (DW < 8) begin : g_bad_dw
      $error("status word needs at least 8 data bits");
   end
   if (SB < 1 || SB >= AW) begin : g_bad_sb
      $error("sector bits must lie inside the address");
   end
   if (PROG_CYC < 1 || PROG_CYC >= LIMIT_CYC) begin : g_bad_prog
      $error("program time must be below the limit");
   end
   if (WIN_CYC < 1 || ERASE_CYC < 1) begin : g_bad_times
      $error("window and erase times must be positive");
   end

   fsg_state_e       eng_state;
   logic             fail_erase;
   logic             prog_commit;
   logic [AW-1:0]    prog_addr;
   logic [DW-1:0]    prog_data;
   logic             erase_commit;
   logic [NSECT-1:0] erase_sel;
   logic [DW-1:0]    rd_word;
   logic [DW-1:0]    chk_word;

   fsg_array #(.DW(DW), .AW(AW), .SB(SB)) u_array (
      .clk          (clk),
      .rst_n        (rst_n),
      .rd_addr      (rd_addr),
      .rd_word      (rd_word),
      .chk_addr     (wr_addr),
      .chk_word     (chk_word),
      .prog_commit  (prog_commit),
      .prog_addr    (prog_addr),
      .prog_data    (prog_data),
      .erase_commit (erase_commit),
      .erase_sel    (erase_sel)
   );

   fsg_engine #(
      .DW(DW), .AW(AW), .SB(SB), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC),
      .WIN_CYC(WIN_CYC), .LIMIT_CYC(LIMIT_CYC), .ERASE_SCALE(ERASE_SCALE)
   ) u_engine (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (wr_en),
      .wr_cmd       (wr_cmd),
      .wr_addr      (wr_addr),
      .wr_data      (wr_data),
      .chk_word     (chk_word),
      .state        (eng_state),
      .fail_erase   (fail_erase),
      .prog_commit  (prog_commit),
      .prog_addr    (prog_addr),
      .prog_data    (prog_data),
      .erase_commit (erase_commit),
      .erase_sel    (erase_sel)
   );

   fsg_status #(.DW(DW)) u_status (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_en      (rd_en),
      .state      (eng_state),
      .fail_erase (fail_erase),
      .rd_word    (rd_word),
      .rd_data    (rd_data)
   );

endmodule

// File: rtl/fsg_chk.sv
module fsg_chk
   import fsg_pkg::*;
#(
   parameter int DW    = 8,
   parameter int NSECT = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [1:0]       wr_cmd,
   input logic             rd_en,
   input logic [DW-1:0]    rd_data,
   input fsg_state_e       state,
   input logic [NSECT-1:0] sel
);
   // R2
   toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && state != ST_IDLE) ##1 (rd_en && state != ST_IDLE)
      |=> rd_data[6] != $past(rd_data[6]));

   // R2
   status_zero_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && state != ST_IDLE) |=> (rd_data[7] == 1'b0 && rd_data[2:0] == 3'b000));

   // R4
   window_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && state == ST_WIN) |=> !rd_data[3]);

   // R6
   erase_set_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ERASE) |=> $stable(sel));

   // R7
   limit_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && state == ST_FAIL) |=> rd_data[5]);

   // R8
   reset_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FAIL && wr_en && wr_cmd == 2'd0) |=> state == ST_IDLE);

endmodule

bind flash_status_gen fsg_chk #(.DW(DW), .NSECT(1 << SB)) u_fsg_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .wr_cmd  (wr_cmd),
   .rd_en   (rd_en),
   .rd_data (rd_data),
   .state   (eng_state),
   .sel     (erase_sel)
);

// File: tb/tb_flash_status_gen.sv
module tb_flash_status_gen;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 8, AW = 4, SB = 2;
   localparam int PROG_CYC = 6, ERASE_CYC = 10, WIN_CYC = 8, LIMIT_CYC = 32;
   localparam int DEPTH = 16;
   localparam int B_IDLE = 0, B_WIN = 1, B_PROG = 2, B_ERASE = 3, B_FAIL = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [1:0]    wr_cmd = '0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic          rd_en = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic [DW-1:0] rd_data;

   int n_chk = 0;
   int n_fail = 0;
   string cur_req = "R1";

   int m_mem [DEPTH];
   int m_state, m_cnt, m_sel, m_paddr, m_pdata, exp_rd;
   bit m_tog, m_fph, m_pbad;

   always #(CLK_PERIOD/2) clk = ~clk;

   flash_status_gen #(
      .DW(DW), .AW(AW), .SB(SB), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC),
      .WIN_CYC(WIN_CYC), .LIMIT_CYC(LIMIT_CYC), .ERASE_SCALE(1)
   ) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cmd(wr_cmd), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
   );

   task automatic chk(string req, int got, int exp, string what);
      n_chk++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s %s: got %0h expected %0h at %0t", req, what, got, exp, $time);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < DEPTH; i++) m_mem[i] = 255;
      m_state = B_IDLE; m_cnt = 0; m_sel = 0; m_paddr = 0; m_pdata = 0;
      exp_rd = 0; m_tog = 0; m_fph = 0; m_pbad = 0;
   endtask

   // What the coming rising edge does, given the inputs held across it.
   task automatic model_edge(bit w, int c, int wa, int wd, bit r, int ra);
      int n, dur;
      if (r) begin
         if (m_state == B_IDLE) exp_rd = m_mem[ra];
         else begin
            m_tog = !m_tog;
            exp_rd = (m_tog ? 64 : 0) | (m_state == B_FAIL ? 32 : 0)
                   | ((m_state == B_FAIL && m_fph) ? 16 : 0)
                   | ((m_state == B_ERASE || (m_state == B_FAIL && m_fph)) ? 8 : 0);
         end
      end
      n = 0;
      for (int s = 0; s < 4; s++) if (m_sel[s]) n++;
      dur = ERASE_CYC * n;
      case (m_state)
         B_IDLE: if (w) begin
            if (c == 1) begin
               m_state = B_PROG; m_cnt = 0; m_paddr = wa; m_pdata = wd;
               m_pbad = (m_mem[wa] & wd) != wd;
            end else if (c == 2) begin
               m_state = B_WIN; m_cnt = 0; m_sel = 1 << (wa >> 2);
            end else if (c == 3) begin
               m_state = B_ERASE; m_cnt = 0; m_sel = 15;
            end
         end
         B_WIN: begin
            if (w && c == 2) m_sel = m_sel | (1 << (wa >> 2));
            if (m_cnt == WIN_CYC - 1) begin m_state = B_ERASE; m_cnt = 0; end
            else m_cnt++;
         end
         B_PROG: begin
            if (!m_pbad && m_cnt == PROG_CYC - 1) begin
               m_mem[m_paddr] = m_mem[m_paddr] & m_pdata; m_state = B_IDLE;
            end else if (m_cnt == LIMIT_CYC - 1) begin m_state = B_FAIL; m_fph = 0; end
            else m_cnt++;
         end
         B_ERASE: begin
            if (dur <= LIMIT_CYC && m_cnt == dur - 1) begin
               for (int i = 0; i < DEPTH; i++) if (m_sel[i >> 2]) m_mem[i] = 255;
               m_state = B_IDLE;
            end else if (m_cnt == LIMIT_CYC - 1) begin m_state = B_FAIL; m_fph = 1; end
            else m_cnt++;
         end
         default: if (w && c == 0) m_state = B_IDLE;
      endcase
   endtask

   // One clock: drive at the falling edge, let the rising edge act, compare at the next falling edge.
   task automatic step(bit w, int c, int wa, int wd, bit r, int ra);
      wr_en = w; wr_cmd = c[1:0]; wr_addr = wa[AW-1:0]; wr_data = wd[DW-1:0];
      rd_en = r; rd_addr = ra[AW-1:0];
      model_edge(w, c, wa, wd, r, ra);
      @(negedge clk);
      chk(cur_req, int'(rd_data), exp_rd, "cycle compare");
   endtask

   task automatic rd(int ra);
      step(0, 0, 0, 0, 1, ra);
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 200000);
      n_chk++; n_fail++;
      $display("FAIL watchdog R1: got hang expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : main
      model_reset();
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1", int'(rd_data), 0, "reset rd_data");
      rst_n = 1'b1;
      @(negedge clk);
      cur_req = "R1";
      rd(3);
      chk("R1", int'(rd_data), 255, "erased word after reset");
      step(0, 0, 0, 0, 0, 7);
      chk("R1", int'(rd_data), 255, "hold without strobe");

      // R8 reset while idle has no effect
      cur_req = "R8";
      step(1, 0, 3, 0, 1, 3);
      rd(3);
      chk("R8", int'(rd_data), 255, "idle reset ignored");

      // R3 program, R2 toggling, R6 ignored write while busy
      cur_req = "R3";
      step(1, 1, 5, 8'h5A, 1, 5);
      chk("R3", int'(rd_data), 255, "read beside accepting write");
      cur_req = "R2";
      rd(5);
      chk("R2", int'(rd_data), 8'h40, "first status read");
      rd(5);
      chk("R2", int'(rd_data), 8'h00, "second status read");
      cur_req = "R6";
      step(1, 3, 0, 0, 1, 5);
      rd(5); rd(5); rd(5);
      cur_req = "R3";
      rd(5);
      chk("R3", int'(rd_data), 8'h5A, "programmed word");
      step(1, 1, 5, 8'h52, 0, 0);
      for (int i = 0; i < PROG_CYC; i++) step(0, 0, 0, 0, 0, 0);
      rd(5);
      chk("R3", int'(rd_data), 8'h52, "AND of old and new");
      step(1, 1, 12, 8'h33, 0, 0);
      for (int i = 0; i < PROG_CYC; i++) rd(12);
      step(1, 1, 9, 8'h44, 1, 12);
      chk("R3", int'(rd_data), 8'h33, "word 12 programmed");
      for (int i = 0; i < PROG_CYC; i++) rd(9);

      // R7 program lock-up and limit
      cur_req = "R7";
      step(1, 1, 5, 8'hFF, 0, 0);
      for (int i = 0; i < LIMIT_CYC + 2; i++) rd(5);
      chk("R7", int'(rd_data[5:3]), 3'b100, "program overrun flags");
      cur_req = "R6";
      step(1, 1, 5, 8'h00, 1, 5);
      cur_req = "R8";
      step(1, 0, 0, 0, 0, 0);
      rd(5);
      chk("R8", int'(rd_data), 8'h52, "reset leaves failed word unchanged");

      // R4 window and R5 sector erase
      cur_req = "R4";
      step(1, 2, 4, 0, 0, 0);
      rd(0);
      chk("R4", int'(rd_data[3]), 0, "window open bit");
      step(1, 2, 9, 0, 1, 0);
      for (int i = 0; i < WIN_CYC - 1; i++) rd(0);
      chk("R4", int'(rd_data[3]), 1, "window closed bit");
      cur_req = "R6";
      step(1, 2, 12, 0, 1, 0);
      for (int i = 0; i < 2 * ERASE_CYC; i++) rd(0);
      cur_req = "R5";
      rd(9);
      chk("R5", int'(rd_data), 255, "sector 2 erased");
      rd(5);
      chk("R5", int'(rd_data), 255, "sector 1 erased");
      rd(12);
      chk("R6", int'(rd_data), 8'h33, "late erase ignored");

      // R5 chip erase start, R7 erase overrun
      cur_req = "R5";
      step(1, 3, 0, 0, 0, 0);
      rd(0);
      chk("R5", int'(rd_data[3]), 1, "chip erase starts at once");
      cur_req = "R7";
      for (int i = 0; i < LIMIT_CYC + 2; i++) rd(0);
      chk("R7", int'(rd_data[5:3]), 3'b111, "erase overrun flags");
      cur_req = "R8";
      step(1, 0, 0, 0, 0, 0);
      rd(12);
      chk("R7", int'(rd_data), 8'h33, "failed erase leaves array");

      // Mixed stimulus: reads nearly every cycle, commands at any phase
      cur_req = "R6";
      for (int i = 0; i < 4000; i++) begin
         int wa, c, wd;
         bit w;
         wa = int'($urandom_range(15, 0));
         c  = int'($urandom_range(3, 0));
         w  = ($urandom_range(7, 0) == 0);
         wd = ($urandom_range(3, 0) == 0) ? int'($urandom_range(255, 0))
                                         : (m_mem[wa] & int'($urandom_range(255, 0)));
         step(w, c, wa, wd, $urandom_range(4, 0) != 0, int'($urandom_range(15, 0)));
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule